// File: doc/BRIEF.md
# Complex Conjugate-Swap Unit

This unit prepares the second operand for complex multiplication on hardware that only multiplies real numbers. A data word carries packed complex samples, each a real part and an imaginary part. For every sample the unit writes, into the same slot, a partner pair made of the negated imaginary part and the untouched real part. A dot product of the original word with another word gives the real part of a conjugate product. A dot product with the partner word gives the imaginary part.

Two packings are supported, chosen per word by a mode input. In the wide packing a 32-bit word holds two samples with 8-bit signed parts. In the narrow packing it holds four samples with 4-bit signed parts. Each negation is confined to its own lane, so no borrow spills into a neighbour. The most negative value of a lane has no positive counterpart, so it comes out unchanged. A per-sample flag reports that case, and the caller is then expected to discard or avoid that input. By default the output is registered with a one-cycle latency, and the valid strobe travels alongside the data.

Top module: `cswap_unit`

## Requirements
- R1: With in_mode = 0 (8-bit mode), the input word holds sample 0 in bits [15:0] and sample 1 in bits [31:16]. Within a sample the real part is the low byte and the imaginary part is the high byte. The output byte 1 equals input byte 0, output byte 3 equals input byte 2, output byte 0 equals the two's-complement negation of input byte 1, and output byte 2 equals the negation of input byte 3.
- R2: Each negation is taken modulo its own lane width. A value of zero or any other value in one lane never changes the output bits of another lane.
- R3: In 8-bit mode an imaginary byte of 0x80 (-128) yields 0x80 in its output byte.
- R4: With in_mode = 1 (4-bit mode), byte k of the word is sample k, with the real part in bits [3:0] and the imaginary part in bits [7:4] of that byte. Output byte k carries the input real nibble in bits [7:4] and the negated imaginary nibble in bits [3:0].
- R5: In 4-bit mode an imaginary nibble of 0x8 (-8) yields 0x8 in its output nibble.
- R6: In 8-bit mode out_minflag[k] is 1 exactly when the imaginary byte of sample k is 0x80, for k = 0 and 1. out_minflag[3:2] is 0.
- R7: In 4-bit mode out_minflag[k] is 1 exactly when the imaginary nibble of sample k (bits [8k+7:8k+4]) is 0x8, for k = 0 to 3.
- R8: out_word and out_minflag reflect the inputs presented on the previous rising clock edge, and out_valid equals in_valid from that same edge.
- R9: While rst is high at a clock edge, out_valid, out_word and out_minflag become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is meaningful |
| in_mode | input | 1 | 0 selects 8-bit parts, 1 selects 4-bit parts |
| in_word | input | 32 | Packed complex samples |
| out_valid | output | 1 | Delayed copy of in_valid |
| out_word | output | 32 | Word of (negated imaginary, real) pairs |
| out_minflag | output | 4 | Per-sample flag for a most-negative imaginary part |

## Verification
Every result is due one clock after its stimulus: the word, the flags and the valid bit all pass through a single register stage. The bench changes the inputs on a falling edge and computes the expected word and flags from its own byte and nibble arithmetic at that moment. It compares them at the next falling edge, half a period after the capturing rising edge. The reset values are read at a falling edge while reset is still held. An idle cycle with the valid bit low is checked in the same way, so the valid bit is shown to follow its input with exactly one cycle of delay.

// File: rtl/cswap_pkg.sv
package cswap_pkg;

    typedef enum logic {
        MODE_B8 = 1'b0,
        MODE_B4 = 1'b1
    } lane_mode_e;

    localparam logic [7:0] MIN8 = 8'h80;
    localparam logic [3:0] MIN4 = 4'h8;

    // one 8-bit-part sample as it sits in the word (imag in upper byte)
    typedef struct packed {
        logic [7:0] im;
        logic [7:0] re;
    } cplx8_t;

    // its partner: real moves up, negated imag takes the low byte
    typedef struct packed {
        logic [7:0] re_hi;
        logic [7:0] nim_lo;
    } swp8_t;

    typedef struct packed {
        logic [3:0] im;
        logic [3:0] re;
    } cplx4_t;

    typedef struct packed {
        logic [3:0] re_hi;
        logic [3:0] nim_lo;
    } swp4_t;

    // lane-local negation, wraps within its own width
    function automatic logic [7:0] neg8(input logic [7:0] v);
        return 8'(8'd0 - v);
    endfunction

    function automatic logic [3:0] neg4(input logic [3:0] v);
        return 4'(4'd0 - v);
    endfunction

endpackage

// File: rtl/cswap_b8.sv
module cswap_b8
    import cswap_pkg::*;
(
    input  cplx8_t smp,
    output swp8_t  res,
    output logic   minf
);

    always_comb begin
        res.re_hi  = smp.re;
        res.nim_lo = neg8(smp.im);
        minf       = (smp.im == MIN8);
    end

    // R2: negated lane plus original wraps to zero inside the byte
    always_comb begin
        assert_b8_wrap_R2: assert (8'(res.nim_lo + smp.im) == 8'd0);
    end

endmodule

// File: rtl/cswap_b4.sv
module cswap_b4
    import cswap_pkg::*;
(
    input  cplx4_t smp,
    output swp4_t  res,
    output logic   minf
);

    always_comb begin
        res.re_hi  = smp.re;
        res.nim_lo = neg4(smp.im);
        minf       = (smp.im == MIN4);
    end

    // R2: nibble negation stays inside the nibble
    always_comb begin
        assert_b4_wrap_R2: assert (4'(res.nim_lo + smp.im) == 4'd0);
    end

endmodule

// File: rtl/cswap_unit.sv
module cswap_unit
    import cswap_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_mode,
    input  logic [WORD_W-1:0]     in_word,
    output logic                  out_valid,
    output logic [WORD_W-1:0]     out_word,
    output logic [WORD_W/8-1:0]   out_minflag
);

    localparam int N8 = WORD_W / 16;
    localparam int N4 = WORD_W / 8;

    lane_mode_e          mode;
    logic [WORD_W-1:0]   word8, word4, word_c;
    logic [N8-1:0]       flag8;
    logic [N4-1:0]       flag4, flag_c;

    assign mode = lane_mode_e'(in_mode);

    for (genvar i = 0; i < N8; i++) begin : g_b8
        cswap_b8 u_b8 (
            .smp  (cplx8_t'(in_word[16*i +: 16])),
            .res  (word8[16*i +: 16]),
            .minf (flag8[i])
        );
    end

    for (genvar j = 0; j < N4; j++) begin : g_b4
        cswap_b4 u_b4 (
            .smp  (cplx4_t'(in_word[8*j +: 8])),
            .res  (word4[8*j +: 8]),
            .minf (flag4[j])
        );
    end

    always_comb begin
        if (mode == MODE_B4) begin
            word_c = word4;
            flag_c = flag4;
        end else begin
            word_c = word8;
            flag_c = '0;
            flag_c[N8-1:0] = flag8;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid   <= 1'b0;
                out_word    <= '0;
                out_minflag <= '0;
            end else begin
                out_valid   <= in_valid;
                out_word    <= word_c;
                out_minflag <= flag_c;
            end
        end

        assert_valid_rise_R8: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        assert_valid_fall_R8: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        assert_b8_real_R1: assert property (@(posedge clk) disable iff (rst)
            (in_mode == 1'b0) |=> (out_word[15:8] == $past(in_word[7:0])
                                   && out_word[31:24] == $past(in_word[23:16])));
        assert_b8_min_R3: assert property (@(posedge clk) disable iff (rst)
            (in_mode == 1'b0 && in_word[15:8] == 8'h80) |=> (out_word[7:0] == 8'h80));
        assert_b4_real_R4: assert property (@(posedge clk) disable iff (rst)
            (in_mode == 1'b1) |=> (out_word[7:4] == $past(in_word[3:0])));
        assert_b4_min_R5: assert property (@(posedge clk) disable iff (rst)
            (in_mode == 1'b1 && in_word[7:4] == 4'h8) |=> (out_word[3:0] == 4'h8));
        assert_b8_flag_hi_R6: assert property (@(posedge clk) disable iff (rst)
            (in_mode == 1'b0) |=> (out_minflag[3:2] == 2'b00));
        assert_b4_flag_R7: assert property (@(posedge clk) disable iff (rst)
            (in_mode == 1'b1 && in_word[31:28] == 4'h8) |=> out_minflag[3]);
    end else begin : g_comb
        assign out_valid   = in_valid;
        assign out_word    = word_c;
        assign out_minflag = flag_c;
    end

endmodule

// File: tb/tb_cswap_unit.sv
module tb_cswap_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_mode;
    logic [31:0] in_word;
    logic        out_valid;
    logic [31:0] out_word;
    logic [3:0]  out_minflag;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    cswap_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_word(in_word), .out_valid(out_valid), .out_word(out_word),
        .out_minflag(out_minflag)
    );

    function automatic int ngt(input int v, input int m);
        return (m - v) % m;
    endfunction

    function automatic logic [31:0] exp_word(input logic md, input logic [31:0] w);
        logic [31:0] r;
        int b0, b1, b2, b3;
        if (!md) begin
            b0 = int'(w[7:0]); b1 = int'(w[15:8]); b2 = int'(w[23:16]); b3 = int'(w[31:24]);
            r[7:0]   = 8'(ngt(b1, 256));
            r[15:8]  = 8'(b0);
            r[23:16] = 8'(ngt(b3, 256));
            r[31:24] = 8'(b2);
        end else begin
            for (int k = 0; k < 4; k++) begin
                r[8*k+4 +: 4] = w[8*k +: 4];
                r[8*k +: 4]   = 4'(ngt(int'(w[8*k+4 +: 4]), 16));
            end
        end
        return r;
    endfunction

    function automatic logic [3:0] exp_flag(input logic md, input logic [31:0] w);
        logic [3:0] f = 4'b0;
        if (!md) begin
            f[0] = (w[15:8] == 8'd128);
            f[1] = (w[31:24] == 8'd128);
        end else begin
            for (int k = 0; k < 4; k++) f[k] = (w[8*k+4 +: 4] == 4'd8);
        end
        return f;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on a falling edge, compare one full cycle later
    task automatic apply(input logic v, input logic md, input logic [31:0] w,
                         input string rw, input string rf);
        logic [31:0] ew = exp_word(md, w);
        logic [3:0]  ef = exp_flag(md, w);
        in_valid = v; in_mode = md; in_word = w;
        @(negedge clk);
        chk(rw, out_word, ew);
        chk(rf, {28'd0, out_minflag}, {28'd0, ef});
        chk("R8", {31'd0, out_valid}, {31'd0, v});
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b1; in_mode = 1'b0; in_word = 32'hFFFF_FFFF;
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        chk("R9", out_word, 32'd0);
        chk("R9", {28'd0, out_minflag}, 32'd0);
        chk("R9", {31'd0, out_valid}, 32'd0);
        rst = 1'b0;

        // directed corners
        apply(1'b1, 1'b0, 32'h0403_0201, "R1", "R6");
        apply(1'b1, 1'b0, 32'h0000_0100, "R2", "R6");   // -1 in lane 0 only
        apply(1'b1, 1'b0, 32'h0100_0000, "R2", "R6");
        apply(1'b1, 1'b0, 32'h8011_8022, "R3", "R6");
        apply(1'b1, 1'b0, 32'h7F00_8000, "R3", "R6");
        apply(1'b0, 1'b0, 32'h1234_5678, "R1", "R6");   // idle cycle
        apply(1'b1, 1'b1, 32'h1010_1010, "R2", "R7");
        apply(1'b1, 1'b1, 32'h8F87_7281, "R5", "R7");
        apply(1'b1, 1'b1, 32'h8888_8888, "R5", "R7");
        apply(1'b1, 1'b1, 32'h7654_3210, "R4", "R7");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic md = 1'($urandom());
            logic [31:0] w = $urandom();
            if ($urandom() % 8 == 0) w[15:8] = 8'h80;
            if ($urandom() % 8 == 0) w[31:28] = 4'h8;
            apply(1'($urandom() % 4 != 0), md, w, md ? "R4" : "R1", md ? "R7" : "R6");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule